// File: doc/BRIEF.md
# I2C Host Register and Interrupt Front End

This block is the byte-wide register file that sits between a CPU bus and the bit-level engine of a single-host I2C controller. It holds the clock divider, the control bits and the transmit byte. It turns writes to the command address into one-cycle command pulses for the engine. It presents the engine's received byte and status flags to the CPU.

The block also owns the interrupt flag. The engine raises `eng_done` each time a commanded byte operation finishes, and that includes the address byte. The flag stays set until software writes the acknowledge bit. The interrupt line is the flag gated by the interrupt-enable control bit. Software programs the divider only while the core is disabled, then sets the enable bit to start normal operation.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the divider reads 0xFFFF, control reads 0x00, the interrupt flag is 0, all command outputs are 0, and `irq` is 0.
- R2: While control bit 7 (core enable) is 0, a write to offset 0 loads the divider's low byte and a write to offset 1 loads its high byte. Both bytes read back at the same offsets and drive `clk_div` from the next cycle.
- R3: While control bit 7 is 1, writes to offsets 0 and 1 leave the divider unchanged.
- R4: Offset 2 holds control bits 7 (core enable → `core_en`), 6 (interrupt enable → `irq_en`) and 5 (controller mode → `host_mode`). Bits 4..0 read as 0.
- R5: A write to offset 3 loads the transmit byte onto `tx_byte`. A read of offset 3 returns `rx_byte`.
- R6: A write to offset 4 produces, in the following cycle only, `cmd_start`, `cmd_stop`, `cmd_read` and `cmd_write` equal to written bits 7, 6, 5 and 4.
- R7: Bit 3 of a command write is held on `cmd_nack` until the next command write.
- R8: A read of offset 4 returns the status: bit 7 `eng_nack`, bit 6 `eng_busy`, bit 5 `eng_arb_lost`, bit 1 `eng_tip`, bit 0 the interrupt flag. Bits 4..2 read as 0.
- R9: `eng_done` sets the interrupt flag at the next edge. A command write with bit 0 set clears it, but when `eng_done` is also high in that same cycle the flag stays set.
- R10: `irq` is high exactly when the interrupt flag and the interrupt-enable bit are both 1.
- R11: Offsets 5 to 7 read as 0 and writes to them change no state. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| clk_div | output | 16 | Divider value to the engine |
| core_en | output | 1 | Core enable |
| irq_en | output | 1 | Interrupt enable |
| host_mode | output | 1 | Controller mode select |
| tx_byte | output | 8 | Byte to transmit |
| cmd_start | output | 1 | Start pulse |
| cmd_stop | output | 1 | Stop pulse |
| cmd_read | output | 1 | Read-byte pulse |
| cmd_write | output | 1 | Write-byte pulse |
| cmd_nack | output | 1 | Send NACK on the next read byte |
| rx_byte | input | 8 | Byte received by the engine |
| eng_done | input | 1 | Byte operation finished (pulse) |
| eng_nack | input | 1 | NACK received |
| eng_busy | input | 1 | Bus busy |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_tip | input | 1 | Transfer in progress |
| irq | output | 1 | Interrupt request, level |

## Verification
Read data is combinational, so the bench checks it in the same cycle as the read, after the inputs settle and before the next rising edge. Writes, command pulses, the latched NACK bit, the interrupt flag and `irq` all take effect at the first rising edge after the stimulus. The bench samples them one time unit after that edge and compares them with a bench model that it advances at the same edge. A command pulse is expected only in the cycle right after its write and low in every other cycle, which catches pulses that stay high too long.

// File: rtl/i2c_host_regs.sv
module i2c_host_regs #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [15:0]   clk_div,
  output logic          core_en,
  output logic          irq_en,
  output logic          host_mode,
  output logic [7:0]    tx_byte,
  output logic          cmd_start,
  output logic          cmd_stop,
  output logic          cmd_read,
  output logic          cmd_write,
  output logic          cmd_nack,
  input  logic [7:0]    rx_byte,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic          eng_busy,
  input  logic          eng_arb_lost,
  input  logic          eng_tip,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_DIV_LO = AW'(0);
  localparam logic [AW-1:0] OFS_DIV_HI = AW'(1);
  localparam logic [AW-1:0] OFS_CTRL   = AW'(2);
  localparam logic [AW-1:0] OFS_DATA   = AW'(3);
  localparam logic [AW-1:0] OFS_CMD    = AW'(4);

  logic [15:0] div_q;
  logic [2:0]  ctrl_q;
  logic [7:0]  tx_q;
  logic [3:0]  pulse_q;
  logic        nack_q;
  logic        flag_q;

  wire sel_wr_cmd = bus_wr && (bus_addr == OFS_CMD);
  wire div_open   = !ctrl_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= 16'hFFFF;
      ctrl_q  <= '0;
      tx_q    <= '0;
      pulse_q <= '0;
      nack_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFS_DIV_LO && div_open) div_q[7:0]  <= bus_wdata;
      if (bus_wr && bus_addr == OFS_DIV_HI && div_open) div_q[15:8] <= bus_wdata;
      if (bus_wr && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[7:5];
      if (bus_wr && bus_addr == OFS_DATA) tx_q   <= bus_wdata;
      pulse_q <= sel_wr_cmd ? bus_wdata[7:4] : 4'b0;
      if (sel_wr_cmd) nack_q <= bus_wdata[3];
      if (eng_done) flag_q <= 1'b1;
      else if (sel_wr_cmd && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DIV_LO: bus_rdata = div_q[7:0];
        OFS_DIV_HI: bus_rdata = div_q[15:8];
        OFS_CTRL:   bus_rdata = {ctrl_q, 5'b0};
        OFS_DATA:   bus_rdata = rx_byte;
        OFS_CMD:    bus_rdata = {eng_nack, eng_busy, eng_arb_lost, 3'b0, eng_tip, flag_q};
        default:    bus_rdata = 8'h00;
      endcase
    end
  end

  assign clk_div   = div_q;
  assign core_en   = ctrl_q[2];
  assign irq_en    = ctrl_q[1];
  assign host_mode = ctrl_q[0];
  assign tx_byte   = tx_q;
  assign {cmd_start, cmd_stop, cmd_read, cmd_write} = pulse_q;
  assign cmd_nack  = nack_q;
  assign irq       = flag_q & ctrl_q[1];
endmodule

// File: rtl/i2c_host_regs_chk.sv
module i2c_host_regs_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [15:0]   clk_div,
  input logic          core_en,
  input logic          irq_en,
  input logic          cmd_start,
  input logic          cmd_nack,
  input logic          eng_done,
  input logic          irq
);
  a_r3_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_en) |-> $stable(clk_div));

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(bus_wr && bus_addr == AW'(4) && bus_wdata[7]));

  a_r7_nack_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> (cmd_nack == $past(bus_wdata[3])));

  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && irq_en && !(bus_wr && bus_addr == AW'(2))) |=> irq);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4) && bus_wdata[0] && !eng_done) |=> !irq);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind i2c_host_regs i2c_host_regs_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_div(clk_div), .core_en(core_en),
  .irq_en(irq_en), .cmd_start(cmd_start), .cmd_nack(cmd_nack), .eng_done(eng_done),
  .irq(irq)
);

// File: tb/test_i2c_host_regs.sv
module test_i2c_host_regs;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [15:0] clk_div;
  logic core_en, irq_en, host_mode;
  logic [7:0] tx_byte, rx_byte;
  logic cmd_start, cmd_stop, cmd_read, cmd_write, cmd_nack;
  logic eng_done, eng_nack, eng_busy, eng_arb_lost, eng_tip, irq;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_div;
  logic [2:0]  m_ctrl;
  logic [7:0]  m_tx;
  logic [3:0]  m_pulse;
  logic        m_nack, m_flag;

  always #(PERIOD/2) clk = ~clk;

  i2c_host_regs i_i2c_host_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic rd, input logic [2:0] a);
    if (!rd) return 8'h00;
    case (a)
      3'd0: return m_div[7:0];
      3'd1: return m_div[15:8];
      3'd2: return {m_ctrl, 5'b0};
      3'd3: return rx_byte;
      3'd4: return {eng_nack, eng_busy, eng_arb_lost, 3'b0, eng_tip, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    logic [2:0] a = bus_addr;
    logic w = bus_wr;
    logic [7:0] d = bus_wdata;
    logic lock = m_ctrl[2];
    if (w && a == 3'd0 && !lock) m_div[7:0]  = d;
    if (w && a == 3'd1 && !lock) m_div[15:8] = d;
    if (w && a == 3'd2) m_ctrl = d[7:5];
    if (w && a == 3'd3) m_tx = d;
    m_pulse = (w && a == 3'd4) ? d[7:4] : 4'b0;
    if (w && a == 3'd4) m_nack = d[3];
    if (eng_done) m_flag = 1'b1;
    else if (w && a == 3'd4 && d[0]) m_flag = 1'b0;
  endtask

  task automatic check_outputs();
    chk("R2/R3 clk_div", clk_div, m_div);
    chk("R4 core_en", core_en, m_ctrl[2]);
    chk("R4 irq_en", irq_en, m_ctrl[1]);
    chk("R4 host_mode", host_mode, m_ctrl[0]);
    chk("R5 tx_byte", tx_byte, m_tx);
    chk("R6 cmd pulses", {cmd_start, cmd_stop, cmd_read, cmd_write}, m_pulse);
    chk("R7 cmd_nack", cmd_nack, m_nack);
    chk("R9/R10 irq", irq, m_flag & m_ctrl[1]);
  endtask

  task automatic cycle(input logic w, input logic r, input logic [2:0] a,
                       input logic [7:0] d, input logic done);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; eng_done = done;
    #1;
    chk("R5/R8/R11 read data", bus_rdata, exp_read(r, a));
    @(posedge clk);
    model_step();
    #1;
    check_outputs();
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rx_byte = 8'h5A; eng_done = 0; eng_nack = 0; eng_busy = 0; eng_arb_lost = 0; eng_tip = 0;
    m_div = 16'hFFFF; m_ctrl = 0; m_tx = 0; m_pulse = 0; m_nack = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1 clk_div", clk_div, 16'hFFFF);
    chk("R1 control", {core_en, irq_en, host_mode}, 3'b0);
    chk("R1 cmd", {cmd_start, cmd_stop, cmd_read, cmd_write, cmd_nack}, 5'b0);
    chk("R1 irq", irq, 1'b0);
    cycle(0, 1, 3'd4, 8'h00, 0);
    // R2 divider program while disabled
    cycle(1, 0, 3'd0, 8'h2C, 0);
    cycle(1, 0, 3'd1, 8'h01, 0);
    cycle(0, 1, 3'd0, 8'h00, 0);
    cycle(0, 1, 3'd1, 8'h00, 0);
    chk("R2 divider", clk_div, 16'h012C);
    // R3 locked once enabled
    cycle(1, 0, 3'd2, 8'hE0, 0);
    cycle(1, 0, 3'd0, 8'h77, 0);
    cycle(1, 0, 3'd1, 8'h88, 0);
    chk("R3 divider locked", clk_div, 16'h012C);
    cycle(0, 1, 3'd2, 8'h00, 0);
    // R9 done and ack in the same cycle: flag stays
    cycle(0, 0, 3'd0, 8'h00, 1);
    cycle(1, 0, 3'd4, 8'h01, 1);
    chk("R9 done beats ack", irq, 1'b1);
    cycle(1, 0, 3'd4, 8'h01, 0);
    chk("R9 ack clears", irq, 1'b0);
    // R11 unmapped offsets
    cycle(1, 1, 3'd5, 8'hFF, 0);
    cycle(1, 1, 3'd7, 8'hFF, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rv = $urandom;
      rx_byte = $urandom;
      {eng_nack, eng_busy, eng_arb_lost, eng_tip} = $urandom;
      cycle(rv[3:0] < 4'd6, rv[4], rv[7:5], $urandom, rv[11:8] == 4'd0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule